// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor Table

This block guesses the direction of conditional branches. It keeps one 2-bit saturating counter per slot in a direct-mapped table. At fetch, some address bits of the branch select a slot. The block returns a taken/not-taken guess in the same cycle, together with the raw counter value it read.

The pipeline carries that counter value alongside the instruction. When the branch resolves, the value comes back with the slot index and the real outcome. The block computes the new counter from the carried value, writes it into the slot, and raises a misprediction flag if the earlier guess was wrong.

A separate priming port lets software load any slot with a chosen state. For example, software can load the slot of an interrupt handler's entry jump before the jump is taken. Branches whose addresses fall on the same slot share one counter.

Top module: `bht_predictor`

## Requirements
- R1: Each slot holds a 2-bit state encoded as 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken, 11 strongly taken. A synchronous active-high reset puts every slot at 01.
- R2: In the same cycle, `pred_snap` equals the stored state of the slot selected by `fetch_pc`, and `pred_taken` equals bit 1 of that state.
- R3: The slot index is `fetch_pc[ALIGN_BITS +: IDX_W]` and is also output on `fetch_idx`. Two addresses that differ only outside those bits share one counter.
- R4: When `res_valid` is high, a taken outcome moves the state up by one and a not-taken outcome moves it down by one. The state holds at 11 and 00 with no wrap. The write takes effect at the next clock edge. When `res_valid` is low, no slot changes.
- R5: The new state is computed from `res_snap`, not from the slot's current content.
- R6: `mispredict` is high in exactly those cycles where `res_valid` is high and bit 1 of `res_snap` differs from `res_taken`.
- R7: When `prime_valid` is high, slot `prime_idx` takes the value `prime_state` at the next clock edge.
- R8: If a priming write and a resolution write hit the same slot in one cycle, the slot takes `prime_state`. If they hit different slots, both writes land.
- R9: A fetch read in a cycle that also writes the same slot returns the value stored before that write.
- R10: Starting from 01, the outcomes T,T,N,N,T,N step the slot through 10,11,10,01,10,01 and give five mispredictions in six branches.
- R11: Strictly alternating outcomes starting at 01 with a taken outcome mispredict on every branch, and the slot swings between 10 and 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | ADDR_W | Branch address at fetch |
| fetch_idx | output | IDX_W | Slot index derived from fetch_pc |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_snap | output | 2 | Counter value read at fetch |
| res_valid | input | 1 | A resolved branch is presented |
| res_idx | input | IDX_W | Slot of the resolved branch |
| res_snap | input | 2 | Counter value carried from fetch |
| res_taken | input | 1 | Actual outcome (1 = taken) |
| mispredict | output | 1 | The carried prediction was wrong |
| prime_valid | input | 1 | Priming write request |
| prime_idx | input | IDX_W | Slot to prime |
| prime_state | input | 2 | State to load |

## Verification
The bench builds the block with 16 slots, a 16-bit address and 2 alignment bits. With only 16 slots, the bench can sweep and read back every slot through the fetch port. The small index also makes random addresses alias onto shared slots often. Random priming and resolution traffic then lands on the same slot in the same cycle frequently enough to exercise the priority rule and the stale-snapshot update. Both also get directed cases.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_WEAK_NT;

    // Outcome of a resolved branch, as seen by the update logic.
    typedef struct packed {
        logic       valid;
        logic [1:0] snap;
        logic       taken;
    } resolve_s;

    // Write request toward the counter storage.
    typedef struct packed {
        logic       en;
        logic [1:0] state;
    } ctr_wr_s;

    function automatic logic ctr_dir(input logic [1:0] s);
        return s[1];
    endfunction

    function automatic logic [1:0] ctr_step(input logic [1:0] s, input logic taken);
        logic [1:0] r;
        if (taken) r = (s == 2'b11) ? s : s + 2'd1;
        else       r = (s == 2'b00) ? s : s - 2'd1;
        return r;
    endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2,
    parameter int IDX_W      = 6
) (
    input  logic [ADDR_W-1:0] pc_i,
    output logic [IDX_W-1:0]  idx_o
);
    // Slot select sits directly above the instruction alignment bits (R3).
    assign idx_o = pc_i[ALIGN_BITS +: IDX_W];
endmodule

// File: rtl/bht_update.sv
module bht_update
    import bht_pkg::*;
(
    input  resolve_s res_i,
    output ctr_wr_s  wr_o,
    output logic     mispredict_o
);
    always_comb begin
        wr_o.en      = res_i.valid;
        // Next state comes from the carried copy, never a fresh read (R5).
        wr_o.state   = ctr_step(res_i.snap, res_i.taken);
        mispredict_o = res_i.valid && (ctr_dir(res_i.snap) != res_i.taken);
    end
endmodule

// File: rtl/bht_ctr_array.sv
module bht_ctr_array
    import bht_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [IDX_W-1:0]         res_idx_i,
    input  ctr_wr_s                  res_wr_i,
    input  logic [IDX_W-1:0]         prime_idx_i,
    input  ctr_wr_s                  prime_wr_i,
    output logic [ENTRIES-1:0][1:0]  state_o
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic       hit_res;
        logic       hit_prime;
        logic [1:0] nxt;
        logic [1:0] q;

        assign hit_res   = res_wr_i.en   && (res_idx_i   == IDX_W'(e));
        assign hit_prime = prime_wr_i.en && (prime_idx_i == IDX_W'(e));
        // Priming takes priority over resolution on the same slot (R8).
        assign nxt = hit_prime ? prime_wr_i.state : res_wr_i.state;

        always_ff @(posedge clk) begin
            if (rst)                       q <= CTR_RESET;
            else if (hit_prime || hit_res) q <= nxt;
        end

        assign state_o[e] = q;
    end
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 64,
    parameter int ALIGN_BITS = 2,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [IDX_W-1:0]  fetch_idx,
    output logic              pred_taken,
    output logic [1:0]        pred_snap,
    input  logic              res_valid,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic [1:0]        res_snap,
    input  logic              res_taken,
    output logic              mispredict,
    input  logic              prime_valid,
    input  logic [IDX_W-1:0]  prime_idx,
    input  logic [1:0]        prime_state
);
    logic [ENTRIES-1:0][1:0] table_q;
    resolve_s                res_bus;
    ctr_wr_s                 res_wr;
    ctr_wr_s                 prime_wr;

    bht_index #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W)) u_index (
        .pc_i  (fetch_pc),
        .idx_o (fetch_idx)
    );

    assign res_bus = '{valid: res_valid, snap: res_snap, taken: res_taken};

    bht_update u_update (
        .res_i        (res_bus),
        .wr_o         (res_wr),
        .mispredict_o (mispredict)
    );

    assign prime_wr = '{en: prime_valid, state: prime_state};

    bht_ctr_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_array (
        .clk         (clk),
        .rst         (rst),
        .res_idx_i   (res_idx),
        .res_wr_i    (res_wr),
        .prime_idx_i (prime_idx),
        .prime_wr_i  (prime_wr),
        .state_o     (table_q)
    );

    // Unbypassed combinational read: same-cycle writes are not visible (R9).
    assign pred_snap  = table_q[fetch_idx];
    assign pred_taken = ctr_dir(pred_snap);
endmodule

// File: rtl/bht_predictor_sva.sv
module bht_predictor_sva #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    res_valid,
    input logic [IDX_W-1:0]        res_idx,
    input logic [1:0]              res_snap,
    input logic                    res_taken,
    input logic                    prime_valid,
    input logic [IDX_W-1:0]        prime_idx,
    input logic [1:0]              prime_state,
    input logic                    mispredict,
    input logic [ENTRIES-1:0][1:0] table_q
);
    logic all_weak_nt;
    logic no_clash;

    always_comb begin
        all_weak_nt = 1'b1;
        for (int i = 0; i < ENTRIES; i++)
            if (table_q[i] != 2'b01) all_weak_nt = 1'b0;
    end

    assign no_clash = !(prime_valid && prime_idx == res_idx);

    a_r1_reset_weak: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> all_weak_nt);

    a_r6_quiet_flag: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !mispredict);

    a_r6_wrong_dir: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_snap[1] != res_taken) |-> mispredict);

    a_r6_right_dir: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_snap[1] == res_taken) |-> !mispredict);

    a_r7_prime_lands: assert property (@(posedge clk) disable iff (rst)
        prime_valid |=> table_q[$past(prime_idx)] == $past(prime_state));

    a_r5_up_from_snap: assert property (@(posedge clk) disable iff (rst)
        (res_valid && no_clash && res_taken && res_snap != 2'b11)
        |=> table_q[$past(res_idx)] == 2'($past(res_snap) + 2'd1));

    a_r5_down_from_snap: assert property (@(posedge clk) disable iff (rst)
        (res_valid && no_clash && !res_taken && res_snap != 2'b00)
        |=> table_q[$past(res_idx)] == 2'($past(res_snap) - 2'd1));

    a_r4_sat_high: assert property (@(posedge clk) disable iff (rst)
        (res_valid && no_clash && res_taken && res_snap == 2'b11)
        |=> table_q[$past(res_idx)] == 2'b11);

    a_r4_sat_low: assert property (@(posedge clk) disable iff (rst)
        (res_valid && no_clash && !res_taken && res_snap == 2'b00)
        |=> table_q[$past(res_idx)] == 2'b00);

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !prime_valid) |=> $stable(table_q));
endmodule

bind bht_predictor bht_predictor_sva #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .res_valid   (res_valid),
    .res_idx     (res_idx),
    .res_snap    (res_snap),
    .res_taken   (res_taken),
    .prime_valid (prime_valid),
    .prime_idx   (prime_idx),
    .prime_state (prime_state),
    .mispredict  (mispredict),
    .table_q     (table_q)
);

// File: tb/bht_predictor_tb_top.sv
`timescale 1ns/1ps
module bht_predictor_tb_top;
    localparam int AW = 16;
    localparam int NE = 16;
    localparam int AL = 2;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] fetch_pc = '0;
    logic [IW-1:0] fetch_idx;
    logic          pred_taken;
    logic [1:0]    pred_snap;
    logic          res_valid = 1'b0;
    logic [IW-1:0] res_idx = '0;
    logic [1:0]    res_snap = '0;
    logic          res_taken = 1'b0;
    logic          mispredict;
    logic          prime_valid = 1'b0;
    logic [IW-1:0] prime_idx = '0;
    logic [1:0]    prime_state = '0;

    int checks = 0;
    int errors = 0;
    logic [1:0] model [NE];

    always #2.5 clk = ~clk;

    bht_predictor #(.ADDR_W(AW), .ENTRIES(NE), .ALIGN_BITS(AL)) dut_i (.*);

    function automatic logic [1:0] m_step(input logic [1:0] s, input logic t);
        if (t) return (s == 2'b11) ? s : s + 2'd1;
        return (s == 2'b00) ? s : s - 2'd1;
    endfunction

    function automatic logic [IW-1:0] m_idx(input logic [AW-1:0] pc);
        return pc[AL +: IW];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called shortly after a falling edge with inputs already driven.
    task automatic tick(input string req);
        logic [IW-1:0] fi;
        #0.5;
        fi = m_idx(fetch_pc);
        chk({req, " R3 idx"}, 32'(fetch_idx), 32'(fi));
        chk({req, " R2 snap"}, 32'(pred_snap), 32'(model[fi]));
        chk({req, " R2 dir"}, 32'(pred_taken), 32'(model[fi][1]));
        chk({req, " R6 flag"}, 32'(mispredict), 32'(res_valid && (res_snap[1] != res_taken)));
        @(posedge clk);
        if (res_valid)   model[res_idx]   = m_step(res_snap, res_taken);
        if (prime_valid) model[prime_idx] = prime_state;
        @(negedge clk);
    endtask

    task automatic idle();
        res_valid = 1'b0;
        prime_valid = 1'b0;
    endtask

    function automatic logic [AW-1:0] pc_of(input int idx, input int hi);
        logic [AW-1:0] p;
        p = AW'(hi) << (AL + IW);
        p[AL +: IW] = IW'(idx);
        p[AL-1:0] = '0;
        return p;
    endfunction

    initial begin
        #(5.0 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int misses;
        logic [1:0] exp_states [6];
        logic       outs [6];
        void'($urandom(32'd20240611));
        for (int i = 0; i < NE; i++) model[i] = 2'b01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every slot reads 01 after reset
        for (int i = 0; i < NE; i++) begin
            fetch_pc = pc_of(i, i);
            #0.5;
            chk("R1 reset state", 32'(pred_snap), 32'h1);
            tick("R1");
        end

        // R3: aliasing addresses share one counter
        fetch_pc = pc_of(3, 7);
        res_valid = 1; res_idx = 3; res_snap = 2'b01; res_taken = 1;
        tick("R3 train");
        idle();
        fetch_pc = pc_of(3, 200);
        #0.5;
        chk("R3 alias shares", 32'(pred_snap), 32'h2);
        tick("R3 alias");

        // R4: saturation at both ends, and no change when res_valid is low
        res_valid = 1; res_idx = 4; res_snap = 2'b11; res_taken = 1;
        fetch_pc = pc_of(4, 0);
        tick("R4 sat hi");
        idle();
        #0.5;
        chk("R4 sat hi", 32'(pred_snap), 32'h3);
        tick("R4");
        res_valid = 1; res_snap = 2'b00; res_taken = 0;
        tick("R4 sat lo");
        idle();
        #0.5;
        chk("R4 sat lo", 32'(pred_snap), 32'h0);
        res_taken = 1; res_snap = 2'b10;
        tick("R4 no valid");
        #0.5;
        chk("R4 no valid no change", 32'(pred_snap), 32'h0);
        tick("R4");

        // R5: a stale carried copy decides the result
        prime_valid = 1; prime_idx = 6; prime_state = 2'b11;
        fetch_pc = pc_of(6, 1);
        tick("R5 prime");
        idle();
        res_valid = 1; res_idx = 6; res_snap = 2'b00; res_taken = 1;
        tick("R5 stale");
        idle();
        #0.5;
        chk("R5 from snapshot", 32'(pred_snap), 32'h1);
        tick("R5");

        // R7/R8/R9: prime wins a same-slot clash; read sees old value
        prime_valid = 1; prime_idx = 9; prime_state = 2'b10;
        res_valid = 1; res_idx = 9; res_snap = 2'b00; res_taken = 0;
        fetch_pc = pc_of(9, 2);
        #0.5;
        chk("R9 old value on write", 32'(pred_snap), 32'h1);
        tick("R8 clash");
        idle();
        #0.5;
        chk("R8 prime wins", 32'(pred_snap), 32'h2);
        tick("R8");
        prime_valid = 1; prime_idx = 10; prime_state = 2'b00;
        res_valid = 1; res_idx = 11; res_snap = 2'b10; res_taken = 1;
        tick("R8 split");
        idle();
        fetch_pc = pc_of(10, 0);
        #0.5;
        chk("R7 prime lands", 32'(pred_snap), 32'h0);
        tick("R7");
        fetch_pc = pc_of(11, 0);
        #0.5;
        chk("R8 both land", 32'(pred_snap), 32'h3);
        tick("R8");

        // R10: trace from 01 with T,T,N,N,T,N
        outs = '{1, 1, 0, 0, 1, 0};
        exp_states = '{2'b10, 2'b11, 2'b10, 2'b01, 2'b10, 2'b01};
        prime_valid = 1; prime_idx = 12; prime_state = 2'b01;
        fetch_pc = pc_of(12, 5);
        tick("R10 prime");
        idle();
        misses = 0;
        for (int k = 0; k < 6; k++) begin
            #0.25;
            res_valid = 1; res_idx = fetch_idx; res_snap = pred_snap; res_taken = outs[k];
            #0.25;
            if (mispredict) misses++;
            tick("R10 step");
            idle();
            #0.25;
            chk("R10 state", 32'(pred_snap), 32'(exp_states[k]));
        end
        chk("R10 mispredict count", 32'(misses), 32'd5);
        tick("R10");

        // R11: alternating outcomes from 01 mispredict every time
        prime_valid = 1; prime_idx = 13; prime_state = 2'b01;
        fetch_pc = pc_of(13, 9);
        tick("R11 prime");
        idle();
        misses = 0;
        for (int k = 0; k < 8; k++) begin
            #0.25;
            res_valid = 1; res_idx = fetch_idx; res_snap = pred_snap; res_taken = (k % 2 == 0);
            #0.25;
            if (mispredict) misses++;
            tick("R11 step");
            idle();
            #0.25;
            chk("R11 swing", 32'(pred_snap), (k % 2 == 0) ? 32'h2 : 32'h1);
        end
        chk("R11 every branch missed", 32'(misses), 32'd8);
        tick("R11");

        // Random traffic: R2 R4 R5 R6 R7 R8 via tick checks
        for (int n = 0; n < 600; n++) begin
            fetch_pc    = AW'($urandom);
            res_valid   = ($urandom % 3) != 0;
            res_idx     = IW'($urandom);
            res_snap    = ($urandom % 2) ? model[res_idx] : 2'($urandom);
            res_taken   = 1'($urandom);
            prime_valid = ($urandom % 6) == 0;
            prime_idx   = ($urandom % 2) ? res_idx : IW'($urandom);
            prime_state = 2'($urandom);
            tick("R4 random");
        end
        idle();
        for (int i = 0; i < NE; i++) begin
            fetch_pc = pc_of(i, 3);
            tick("R7 final sweep");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule